// File: doc/BRIEF.md
# Calendar Time-of-Year Counter

This block keeps wall-clock time for a chip from a 32.768 kHz oscillator clock. A programmable prescaler divides that clock into a one-second tick. The tick advances a packed time-and-date word and a separate year word. The time word holds seconds, minutes, hours, day of month and month. The year word holds the full binary year.

Software reaches the block through a plain 32-bit register bus. The bus has a write strobe, a byte offset, write data, and read data that follows the offset combinationally. Writes to the trim register and to the two time-set registers do not take effect at once. Each is held in a pending slot and committed a fixed number of oscillator cycles later. The control/status word shows which commits are still pending, so a driver can poll until its write has landed.

Top module: `cal_counter`

## Requirements
- R1: After reset, the time read word (0x0C) is 0x04200000, which is month 1, day 1, 00:00:00. The year read word (0x10) is 2000, the trim register (0x00) is 32767, and the status word (0x20) is 0x00000120.
- R2: The packed time word places seconds in bits [9:4], minutes in [15:10], hours in [20:16], day in [25:21] and month (January = 1) in [31:26]. Bits [3:0] always read 0, even when a nonzero value was written there.
- R3: The year is a full binary number. It is written at 0x08 and read at 0x10, unchanged and with no offset applied.
- R4: With trim value T, the second count advances once every T+1 oscillator cycles. A commit of either the trim register or the time-set word restarts the prescaler, so the first advance after such a commit comes T+1 cycles later.
- R5: A value written to 0x00, 0x04 or 0x08 appears in its readable register exactly 3 clock cycles after the write. Until then the readable register keeps its old value.
- R6: Status bit 0 reads 1 for exactly the 3 cycles during which a time-set word (0x04) or year word (0x08) commit is pending. It reads 0 otherwise.
- R7: Status bit 4 reads 1 for exactly the 3 cycles during which a trim commit is pending.
- R8: A second write to the same register while its commit is pending replaces the pending value and restarts the 3-cycle delay. The first value never appears.
- R9: On a tick, seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R10: The day wraps to 1 and carries into the month after the last day of the month. That last day comes from a fixed table, in which February has 29 days when the year is divisible by 4 and 28 days otherwise.
- R11: After month 12 the month wraps to 1 and the year increments by one.
- R12: Status bits 8 (oscillator enabled) and 5 (32 kHz clock present) always read 1.
- R13: Registers sit at trim 0x00, time-set 0x04, year-set 0x08, time-read 0x0C, year-read 0x10 and status 0x20. Every other offset, including the two set offsets, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (32.768 kHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (6) | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |

## Verification
The hardest cases to reach are the calendar carries: end of month, leap February and year end. With the reset trim, one second takes 32768 cycles, and a carry across a full month is out of reach. The stimulus first commits a trim of 3, which gives a four-cycle second. It then commits a year and a time word set to one second before each boundary. Because the time commit restarts the prescaler, the carry lands on a known cycle, and the bench checks the cycle before it and the cycle of the carry. The restart of a pending commit is reached with two writes on consecutive cycles.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int DATA_W = 32;

    // Register byte offsets; a driver decodes these
    localparam logic [7:0] OFS_TRIM   = 8'h00;
    localparam logic [7:0] OFS_SET_LO = 8'h04;
    localparam logic [7:0] OFS_SET_HI = 8'h08;
    localparam logic [7:0] OFS_GET_LO = 8'h0C;
    localparam logic [7:0] OFS_GET_HI = 8'h10;
    localparam logic [7:0] OFS_STAT   = 8'h20;

    // Status word bit positions
    localparam int ST_TIME_BUSY = 0;
    localparam int ST_TRIM_BUSY = 4;
    localparam int ST_XTAL_OK   = 5;
    localparam int ST_OSC_ON    = 8;

    // Packed time-of-year word, MSB first
    typedef struct packed {
        logic [5:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
        logic [3:0] pad;
    } tod_t;

    localparam tod_t TOD_RESET = '{mon: 6'd1, day: 5'd1, hour: 5'd0,
                                   min: 6'd0, sec: 6'd0, pad: 4'd0};
    localparam logic [31:0] YEAR_RESET = 32'd2000;

    function automatic logic [4:0] month_len(input logic [5:0] m, input logic leap);
        case (m)
            6'd2:                      month_len = leap ? 5'd29 : 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11:   month_len = 5'd30;
            default:                   month_len = 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_commit.sv
module cal_commit #(
    parameter int W     = 32,
    parameter int DELAY = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         busy,
    output logic         fire,
    output logic [W-1:0] pend
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= '0;
        end else if (load) begin
            cnt  <= CW'(DELAY);
            pend <= din;
        end else if (cnt != '0) begin
            cnt  <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign fire = (cnt == CW'(1)) && !load;
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] trim,
    input  logic          restart,
    output logic          tick
);
    logic [TW-1:0] pcnt;

    assign tick = (pcnt == trim) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || tick) pcnt <= '0;
        else                        pcnt <= pcnt + TW'(1);
    end
endmodule

// File: rtl/cal_calendar.sv
module cal_calendar
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        lo_load,
    input  tod_t        lo_val,
    input  logic        hi_load,
    input  logic [31:0] hi_val,
    output tod_t        tod,
    output logic [31:0] year
);
    tod_t nxt;
    logic c_min, c_hour, c_day, c_mon, c_year;
    logic leap;

    always_comb begin
        leap   = (year[1:0] == 2'b00);
        nxt    = tod;
        nxt.pad = 4'd0;
        c_min  = (tod.sec  == 6'd59);
        c_hour = c_min  && (tod.min  == 6'd59);
        c_day  = c_hour && (tod.hour == 5'd23);
        c_mon  = c_day  && (tod.day  >= month_len(tod.mon, leap));
        c_year = c_mon  && (tod.mon  >= 6'd12);
        nxt.sec = c_min ? 6'd0 : tod.sec + 6'd1;
        if (c_min)  nxt.min  = (tod.min == 6'd59) ? 6'd0 : tod.min + 6'd1;
        if (c_hour) nxt.hour = (tod.hour == 5'd23) ? 5'd0 : tod.hour + 5'd1;
        if (c_day)  nxt.day  = c_mon ? 5'd1 : tod.day + 5'd1;
        if (c_mon)  nxt.mon  = c_year ? 6'd1 : tod.mon + 6'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tod <= TOD_RESET;
        end else if (lo_load) begin
            tod     <= lo_val;
            tod.pad <= 4'd0;
        end else if (tick) begin
            tod <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 year <= YEAR_RESET;
        else if (hi_load)        year <= hi_val;
        else if (tick && c_year) year <= year + 32'd1;
    end
endmodule

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int TRIM_W     = 16,
    parameter int COMMIT_CYC = 3,
    parameter int TRIM_RESET = 32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] A_TRIM   = OFS_TRIM[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_SET_LO = OFS_SET_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_SET_HI = OFS_SET_HI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_GET_LO = OFS_GET_LO[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_GET_HI = OFS_GET_HI[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_STAT   = OFS_STAT[ADDR_W-1:0];

    logic              trim_busy, trim_fire;
    logic [TRIM_W-1:0] trim_pend, trim_q;
    logic              lo_busy, lo_fire;
    logic [31:0]       lo_pend;
    logic              hi_busy, hi_fire;
    logic [31:0]       hi_pend;
    logic              tick;
    tod_t              tod_q;
    logic [31:0]       year_q;
    logic [31:0]       stat;

    cal_commit #(.W(TRIM_W), .DELAY(COMMIT_CYC)) u_trim_slot (
        .clk(clk), .rst(rst),
        .load(bus_we && bus_addr == A_TRIM),
        .din(bus_wdata[TRIM_W-1:0]),
        .busy(trim_busy), .fire(trim_fire), .pend(trim_pend)
    );

    cal_commit #(.W(32), .DELAY(COMMIT_CYC)) u_lo_slot (
        .clk(clk), .rst(rst),
        .load(bus_we && bus_addr == A_SET_LO),
        .din(bus_wdata),
        .busy(lo_busy), .fire(lo_fire), .pend(lo_pend)
    );

    cal_commit #(.W(32), .DELAY(COMMIT_CYC)) u_hi_slot (
        .clk(clk), .rst(rst),
        .load(bus_we && bus_addr == A_SET_HI),
        .din(bus_wdata),
        .busy(hi_busy), .fire(hi_fire), .pend(hi_pend)
    );

    always_ff @(posedge clk) begin
        if (rst)            trim_q <= TRIM_W'(TRIM_RESET);
        else if (trim_fire) trim_q <= trim_pend;
    end

    cal_prescaler #(.TW(TRIM_W)) u_presc (
        .clk(clk), .rst(rst), .trim(trim_q),
        .restart(trim_fire || lo_fire), .tick(tick)
    );

    cal_calendar u_cal (
        .clk(clk), .rst(rst), .tick(tick),
        .lo_load(lo_fire), .lo_val(tod_t'(lo_pend)),
        .hi_load(hi_fire), .hi_val(hi_pend),
        .tod(tod_q), .year(year_q)
    );

    always_comb begin
        stat               = '0;
        stat[ST_TIME_BUSY] = lo_busy || hi_busy;
        stat[ST_TRIM_BUSY] = trim_busy;
        stat[ST_XTAL_OK]   = 1'b1;
        stat[ST_OSC_ON]    = 1'b1;
    end

    always_comb begin
        case (bus_addr)
            A_TRIM:   bus_rdata = 32'(trim_q);
            A_GET_LO: bus_rdata = tod_q;
            A_GET_HI: bus_rdata = year_q;
            A_STAT:   bus_rdata = stat;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk #(
    parameter int ADDR_W = 6,
    parameter int TRIM_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              trim_busy,
    input logic              trim_fire,
    input logic [TRIM_W-1:0] trim_pend,
    input logic [TRIM_W-1:0] trim_q,
    input logic              tick,
    input logic              lo_fire,
    input logic              hi_fire,
    input logic [5:0]        sec,
    input logic [31:0]       year
);
    // R7: a trim write raises the trim-busy flag on the next cycle
    assert_trim_busy_R7: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr == ADDR_W'(0) |=> trim_busy);

    // R5: a trim commit lands the pending value
    assert_trim_commit_R5: assert property (@(posedge clk) disable iff (rst)
        trim_fire |=> trim_q == $past(trim_pend));

    // R4: ticks are spaced by trim+1 cycles, so two in a row need trim 0
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick && trim_q != '0 |=> !tick);

    // R9: seconds wrap from 59 to 0 on a tick
    assert_sec_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        tick && !lo_fire && sec == 6'd59 |=> sec == 6'd0);

    // R11: the year moves only on a tick or a year commit
    assert_year_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !hi_fire && !tick |=> $stable(year));
endmodule

bind cal_counter cal_counter_chk #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .trim_busy(trim_busy), .trim_fire(trim_fire), .trim_pend(trim_pend),
    .trim_q(trim_q), .tick(tick), .lo_fire(lo_fire), .hi_fire(hi_fire),
    .sec(tod_q.sec), .year(year_q)
);

// File: tb/cal_counter_bench.sv
module cal_counter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cal_counter u_cal_counter (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] pk(input int mo, input int d, input int h,
                                       input int mi, input int s);
        pk = {6'(mo), 5'(d), 5'(h), 6'(mi), 6'(s), 4'd0};
    endfunction

    // Caller is at a falling edge; returns at the next falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_reg(input logic [5:0] a, input logic [31:0] exp,
                              input string req);
        logic [31:0] got;
        bus_addr = a;
        #1;
        got = bus_rdata;
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    task automatic t_reset;
        expect_reg(6'h0C, 32'h0420_0000, "R1");
        expect_reg(6'h10, 32'd2000, "R1");
        expect_reg(6'h00, 32'd32767, "R1");
        expect_reg(6'h20, 32'h0000_0120, "R1 R12");
    endtask

    task automatic t_map;
        expect_reg(6'h04, 32'd0, "R13");
        expect_reg(6'h08, 32'd0, "R13");
        expect_reg(6'h14, 32'd0, "R13");
        expect_reg(6'h3C, 32'd0, "R13");
    endtask

    // Trim commit: busy bit 4 for exactly 3 cycles, value lands on the third
    task automatic t_trim;
        wr(6'h00, 32'd3);
        expect_reg(6'h20, 32'h0000_0130, "R7");
        expect_reg(6'h00, 32'd32767, "R5");
        @(negedge clk);
        expect_reg(6'h20, 32'h0000_0130, "R7");
        @(negedge clk);
        expect_reg(6'h20, 32'h0000_0130, "R7");
        expect_reg(6'h00, 32'd32767, "R5");
        @(negedge clk);
        expect_reg(6'h20, 32'h0000_0120, "R7 R12");
        expect_reg(6'h00, 32'd3, "R5");
    endtask

    // Year commit with a rewrite one cycle later
    task automatic t_year;
        wr(6'h08, 32'd1999);
        expect_reg(6'h20, 32'h0000_0121, "R6");
        wr(6'h08, 32'd2100);
        @(negedge clk);
        @(negedge clk);
        expect_reg(6'h10, 32'd2000, "R8");
        expect_reg(6'h20, 32'h0000_0121, "R6 R8");
        @(negedge clk);
        expect_reg(6'h10, 32'd2100, "R3 R8");
        expect_reg(6'h20, 32'h0000_0120, "R6");
    endtask

    // Set year and time, then expect one advance exactly trim+1 cycles later
    task automatic t_step(input int yr, input logic [31:0] t0, input logic [31:0] t1,
                          input int yr1, input string req);
        wr(6'h08, yr);
        repeat (3) @(negedge clk);
        wr(6'h04, t0);
        expect_reg(6'h20, 32'h0000_0121, "R6");
        repeat (3) @(negedge clk);
        expect_reg(6'h0C, t0 & 32'hFFFF_FFF0, {req, " R2 R5"});
        repeat (3) @(negedge clk);
        expect_reg(6'h0C, t0 & 32'hFFFF_FFF0, {req, " R4"});
        @(negedge clk);
        expect_reg(6'h0C, t1, req);
        expect_reg(6'h10, yr1, req);
    endtask

    // Period check: the following advance comes 4 cycles after the first
    task automatic t_period;
        t_step(2024, pk(3, 5, 6, 7, 8), pk(3, 5, 6, 7, 9), 2024, "R4");
        repeat (3) @(negedge clk);
        expect_reg(6'h0C, pk(3, 5, 6, 7, 9), "R4");
        @(negedge clk);
        expect_reg(6'h0C, pk(3, 5, 6, 7, 10), "R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_trim();
        t_year();
        t_period();
        t_step(2024, pk(6, 2, 3, 4, 58) | 32'hF, pk(6, 2, 3, 4, 59), 2024, "R2");
        t_step(2024, pk(6, 2, 10, 59, 59), pk(6, 2, 11, 0, 0), 2024, "R9");
        t_step(2024, pk(6, 2, 23, 59, 59), pk(6, 3, 0, 0, 0), 2024, "R9");
        t_step(2023, pk(2, 28, 23, 59, 59), pk(3, 1, 0, 0, 0), 2023, "R10");
        t_step(2024, pk(2, 28, 23, 59, 59), pk(2, 29, 0, 0, 0), 2024, "R10");
        t_step(2024, pk(2, 29, 23, 59, 59), pk(3, 1, 0, 0, 0), 2024, "R10");
        t_step(2024, pk(4, 30, 23, 59, 59), pk(5, 1, 0, 0, 0), 2024, "R10");
        t_step(2024, pk(7, 30, 23, 59, 59), pk(7, 31, 0, 0, 0), 2024, "R10");
        t_step(2023, pk(12, 31, 23, 59, 59), pk(1, 1, 0, 0, 0), 2024, "R11");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule